// File: doc/BRIEF.md
# Update-Protocol Line Coherence Controller

This block tracks the coherence state of each line of a small write-back cache in a snooping multiprocessor that keeps other copies current by broadcasting writes instead of invalidating them. A line is either empty, clean and held only here, clean and held by several caches, or modified and held only here. A modified line is never shared. Whether another cache holds a line is learned from a wired-OR shared signal on the bus. The block also drives that signal whenever one of its own lines is named by another cache's bus read or write.

Each cycle the block takes at most one processor request (read or write to a line address) and at most one snooped bus event (read, write broadcast or write miss). It answers combinationally with the bus command the processor request needs, a memory-update strobe, a dirty-victim write-back flag, the shared-line drive, a local-copy update strobe and the next state of both addressed lines. The new states are stored at the next rising clock edge. Data arrays and bus arbitration sit outside the block.

Top module: `coh_update_ctrl`

## Requirements
- R1: Reset (rst_n low) empties every line. While reset is held with no requests, all strobes are 0, bus_cmd is 0 and both next-state outputs are 0. After reset, every processor access misses.
- R2: Line states are encoded as empty=0, exclusive-clean=1, shared-clean=2, dirty=3. Bus commands are encoded as none=0, read=1, write-miss=2, update=3. A processor read miss issues read (1), and the line becomes shared (2) if sl_in is high and exclusive (1) if it is low.
- R3: A processor read hit issues no command, leaves the state unchanged, and the line stays valid in later cycles.
- R4: A processor write hit on an exclusive line makes it dirty without any bus command or memory update. A write hit on a dirty line leaves everything quiet.
- R5: A processor write hit on a shared line issues update (3) and pulses mem_upd. The line stays shared if sl_in is high and becomes exclusive if sl_in is low.
- R6: A processor write miss issues write-miss (2). With sl_in high, the line becomes shared and mem_upd pulses. With sl_in low, the line becomes dirty and mem_upd stays low.
- R7: A snooped read (snoop_kind=1) that hits a valid line drives sl_drive and leaves the line shared. A dirty line additionally pulses mem_upd. It never pulses snoop_local_upd.
- R8: A snooped write broadcast (snoop_kind=2) or write miss (snoop_kind=3) that hits a valid line drives sl_drive, pulses snoop_local_upd and leaves the line shared. A dirty line additionally pulses mem_upd.
- R9: A snoop whose tag does not match, or which names an empty line, drives nothing, reports next state 0 and changes no stored state.
- R10: A processor miss whose index holds a dirty line of another tag pulses evict_wb alongside the command. A clean victim does not.
- R11: When a snoop and a processor request fall in the same cycle on the same line, the snoop's transition is applied first and the processor transition starts from the result. Requests on different lines proceed independently.
- R12: The low IDX_W bits of a line address select the line and the remaining bits form its tag. Two addresses with equal index and different tags displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor line address |
| sl_in | input | 1 | Shared signal seen on the bus for this processor transaction |
| snoop_kind | input | 2 | 0 none, 1 read, 2 write broadcast, 3 write miss |
| snoop_addr | input | ADDR_W | Snooped line address |
| bus_cmd | output | 2 | Command to issue for the processor request |
| mem_upd | output | 1 | Memory must take the line's data this cycle |
| evict_wb | output | 1 | Dirty victim must be written back |
| sl_drive | output | 1 | Assert the shared signal for the snooped transaction |
| snoop_local_upd | output | 1 | Write broadcast data into the local copy |
| cpu_hit | output | 1 | Processor request hits a valid line |
| cpu_next_state | output | 2 | State of the processor line after this cycle |
| snoop_next_state | output | 2 | State of the snooped line after this cycle (0 on a miss) |

## Verification
A snoop and a processor request can land in the same cycle, and on the same line. The bench provokes this by driving both at once. A dirty line that is snooped while the processor writes it must first flush and become shared, and the write must then go out as an update broadcast. A dirty line that is snooped while the processor misses on its index must not be reported as a dirty victim, because the snoop has already cleaned it. The outputs of both sides are judged in that single cycle, and later accesses confirm which state was stored.

// File: rtl/coh_upd_pkg.sv
// Package: shared encodings and result bundles for the update-protocol
// coherence controller. Assumes two-bit state and command fields.
package coh_upd_pkg;

    typedef enum logic [1:0] {
        LS_INV   = 2'd0,
        LS_EXCL  = 2'd1,
        LS_SHRD  = 2'd2,
        LS_DIRTY = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_READ   = 2'd1,
        BC_WRMISS = 2'd2,
        BC_UPDATE = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        SK_NONE   = 2'd0,
        SK_READ   = 2'd1,
        SK_UPDATE = 2'd2,
        SK_WRMISS = 2'd3
    } snoop_kind_e;

    typedef struct packed {
        line_st_e nxt;
        logic     sl_drv;
        logic     flush;
        logic     local_upd;
    } snoop_res_t;

    typedef struct packed {
        line_st_e nxt;
        bus_cmd_e cmd;
        logic     mem_upd;
        logic     evict;
    } cpu_res_t;

endpackage

// File: rtl/coh_line_store.sv
// Module: per-line state and tag registers. Two combinational read ports
// (snoop side, processor side) and two write ports. When both write the
// same line, the processor port wins because its value already includes
// the snoop effect. Assumes synchronous active-low reset.
module coh_line_store
    import coh_upd_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] s_rd_idx,
    output line_st_e         s_rd_st,
    output logic [TAG_W-1:0] s_rd_tag,
    input  logic [IDX_W-1:0] c_rd_idx,
    output line_st_e         c_rd_st,
    output logic [TAG_W-1:0] c_rd_tag,
    input  logic             s_we,
    input  line_st_e         s_wr_st,
    input  logic             c_we,
    input  line_st_e         c_wr_st,
    input  logic [TAG_W-1:0] c_wr_tag
);
    localparam int LINES = 1 << IDX_W;

    line_st_e         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Purpose: update one line from whichever port targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i]  <= LS_INV;
                tag_q[i] <= '0;
            end else if (c_we && (c_rd_idx == IDX_W'(i))) begin
                st_q[i]  <= c_wr_st;
                tag_q[i] <= c_wr_tag;
            end else if (s_we && (s_rd_idx == IDX_W'(i))) begin
                st_q[i]  <= s_wr_st;
            end
        end
    end

    // Purpose: present the addressed lines to both state machines.
    always_comb begin
        s_rd_st  = st_q[s_rd_idx];
        s_rd_tag = tag_q[s_rd_idx];
        c_rd_st  = st_q[c_rd_idx];
        c_rd_tag = tag_q[c_rd_idx];
    end

endmodule

// File: rtl/coh_snoop_fsm.sv
// Module: snoop-side transition. Any hit on a valid line drives the shared
// signal and leaves the line shared; a dirty line is flushed to memory;
// write broadcasts and write misses refresh the local copy. Assumes `hit`
// already includes tag match and a valid line.
module coh_snoop_fsm
    import coh_upd_pkg::*;
(
    input  snoop_kind_e kind,
    input  logic        hit,
    input  line_st_e    cur,
    output snoop_res_t  res
);
    // Purpose: compute snoop outcome for the addressed line.
    always_comb begin
        res.nxt       = cur;
        res.sl_drv    = 1'b0;
        res.flush     = 1'b0;
        res.local_upd = 1'b0;
        if (hit && (kind != SK_NONE)) begin
            res.sl_drv    = 1'b1;
            res.nxt       = LS_SHRD;
            res.flush     = (cur == LS_DIRTY);
            res.local_upd = (kind != SK_READ);
        end
    end

endmodule

// File: rtl/coh_cpu_fsm.sv
// Module: processor-side transition. Works from the post-snoop state of the
// addressed line. Shared writes broadcast and update memory; the shared
// signal picks the state after fills and broadcasts. Assumes sl_in is
// valid in the same cycle as the request.
module coh_cpu_fsm
    import coh_upd_pkg::*;
(
    input  logic     valid,
    input  logic     write,
    input  logic     hit,
    input  line_st_e cur,
    input  logic     sl,
    output cpu_res_t res
);
    // Purpose: compute command, strobes and next state for the request.
    always_comb begin
        res.nxt     = cur;
        res.cmd     = BC_NONE;
        res.mem_upd = 1'b0;
        res.evict   = 1'b0;
        if (valid) begin
            if (hit) begin
                if (write) begin
                    unique case (cur)
                        LS_EXCL:  res.nxt = LS_DIRTY;
                        LS_SHRD: begin
                            res.cmd     = BC_UPDATE;
                            res.mem_upd = 1'b1;
                            res.nxt     = sl ? LS_SHRD : LS_EXCL;
                        end
                        default:  res.nxt = cur;
                    endcase
                end
            end else begin
                res.evict = (cur == LS_DIRTY);
                if (write) begin
                    res.cmd     = BC_WRMISS;
                    res.mem_upd = sl;
                    res.nxt     = sl ? LS_SHRD : LS_DIRTY;
                end else begin
                    res.cmd = BC_READ;
                    res.nxt = sl ? LS_SHRD : LS_EXCL;
                end
            end
        end
    end

endmodule

// File: rtl/coh_update_ctrl.sv
// Module: top of the update-protocol coherence controller. Splits addresses
// into index and tag, applies the snoop first, feeds the post-snoop state of
// the processor line into the processor transition, and stores both results
// at the clock edge. All outputs are combinational in the request cycle.
module coh_update_ctrl
    import coh_upd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              sl_in,
    input  logic [1:0]        snoop_kind,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic [1:0]        bus_cmd,
    output logic              mem_upd,
    output logic              evict_wb,
    output logic              sl_drive,
    output logic              snoop_local_upd,
    output logic              cpu_hit,
    output logic [1:0]        cpu_next_state,
    output logic [1:0]        snoop_next_state
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] s_idx, c_idx;
    logic [TAG_W-1:0] s_tag, c_tag;
    line_st_e         s_st, c_st, c_post;
    logic [TAG_W-1:0] s_tag_q, c_tag_q;
    logic             s_hit, c_hit;
    snoop_kind_e      kind;
    snoop_res_t       s_res;
    cpu_res_t         c_res;

    // Purpose: split addresses and decode the snoop kind (R12).
    always_comb begin
        s_idx = snoop_addr[IDX_W-1:0];
        s_tag = snoop_addr[ADDR_W-1:IDX_W];
        c_idx = cpu_addr[IDX_W-1:0];
        c_tag = cpu_addr[ADDR_W-1:IDX_W];
        kind  = snoop_kind_e'(snoop_kind);
    end

    coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_rd_idx (s_idx),
        .s_rd_st  (s_st),
        .s_rd_tag (s_tag_q),
        .c_rd_idx (c_idx),
        .c_rd_st  (c_st),
        .c_rd_tag (c_tag_q),
        .s_we     (s_hit),
        .s_wr_st  (s_res.nxt),
        .c_we     (cpu_valid),
        .c_wr_st  (c_res.nxt),
        .c_wr_tag (c_tag)
    );

    // Purpose: snoop hit detection on the stored line (R9).
    always_comb begin
        s_hit = (kind != SK_NONE) && (s_st != LS_INV) && (s_tag_q == s_tag);
    end

    coh_snoop_fsm u_snoop (
        .kind (kind),
        .hit  (s_hit),
        .cur  (s_st),
        .res  (s_res)
    );

    // Purpose: snoop-before-processor ordering on a shared line (R11).
    always_comb begin
        c_post = (s_hit && (s_idx == c_idx)) ? s_res.nxt : c_st;
        c_hit  = (c_post != LS_INV) && (c_tag_q == c_tag);
    end

    coh_cpu_fsm u_cpu (
        .valid (cpu_valid),
        .write (cpu_write),
        .hit   (c_hit),
        .cur   (c_post),
        .sl    (sl_in),
        .res   (c_res)
    );

    // Purpose: drive the block outputs.
    always_comb begin
        bus_cmd          = c_res.cmd;
        mem_upd          = c_res.mem_upd | s_res.flush;
        evict_wb         = c_res.evict;
        sl_drive         = s_res.sl_drv;
        snoop_local_upd  = s_res.local_upd;
        cpu_hit          = cpu_valid && c_hit;
        cpu_next_state   = cpu_valid ? c_res.nxt : LS_INV;
        snoop_next_state = s_hit ? s_res.nxt : LS_INV;
    end

endmodule

// File: rtl/coh_update_ctrl_chk.sv
// Module: protocol checker bound to coh_update_ctrl. Observes ports only.
module coh_update_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_write,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              sl_in,
    input logic [1:0]        snoop_kind,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic [1:0]        bus_cmd,
    input logic              mem_upd,
    input logic              evict_wb,
    input logic              sl_drive,
    input logic              snoop_local_upd,
    input logic              cpu_hit,
    input logic [1:0]        cpu_next_state,
    input logic [1:0]        snoop_next_state
);
    logic seen;

    // Purpose: mark that the previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_read_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd == 2'd1 |-> (cpu_valid && !cpu_write && !cpu_hit &&
                             cpu_next_state == (sl_in ? 2'd2 : 2'd1)));

    assert_line_retained_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && cpu_valid && $past(cpu_valid) && cpu_addr == $past(cpu_addr)) |-> cpu_hit);

    assert_excl_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_write && cpu_hit && bus_cmd == 2'd0) |-> cpu_next_state == 2'd3);

    assert_update_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd == 2'd3 |-> (mem_upd && cpu_hit && cpu_write &&
                             cpu_next_state == (sl_in ? 2'd2 : 2'd1)));

    assert_wrmiss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd == 2'd2 |-> (!cpu_hit && cpu_write &&
                             cpu_next_state == (sl_in ? 2'd2 : 2'd3)));

    assert_sl_on_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sl_drive |-> (snoop_kind != 2'd0 && snoop_next_state == 2'd2));

    assert_local_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_local_upd |-> (sl_drive && snoop_kind[1]));

    assert_snoop_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_next_state == 2'd0) |-> (!sl_drive && !snoop_local_upd));

    assert_evict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evict_wb |-> (!cpu_hit && (bus_cmd == 2'd1 || bus_cmd == 2'd2)));

endmodule

bind coh_update_ctrl coh_update_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/coh_update_ctrl_test.sv
// Bench: table-driven walk through the protocol, then a reset test.
module coh_update_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 1'b0, cpu_write = 1'b0, sl_in = 1'b0;
    logic [7:0] cpu_addr = '0, snoop_addr = '0;
    logic [1:0] snoop_kind = '0;
    logic [1:0] bus_cmd, cpu_next_state, snoop_next_state;
    logic       mem_upd, evict_wb, sl_drive, snoop_local_upd, cpu_hit;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    coh_update_ctrl #(.ADDR_W(8), .IDX_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .sl_in(sl_in), .snoop_kind(snoop_kind),
        .snoop_addr(snoop_addr), .bus_cmd(bus_cmd), .mem_upd(mem_upd),
        .evict_wb(evict_wb), .sl_drive(sl_drive), .snoop_local_upd(snoop_local_upd),
        .cpu_hit(cpu_hit), .cpu_next_state(cpu_next_state),
        .snoop_next_state(snoop_next_state)
    );

    typedef struct packed {
        logic       cv; logic cw; logic [7:0] ca; logic sl;
        logic [1:0] sk; logic [7:0] sa;
        logic [1:0] cmd; logic mem; logic ev; logic sld; logic loc; logic hit;
        logic [1:0] cn; logic [1:0] sn; logic [3:0] req;
    } vec_t;

    localparam int NV = 34;
    // Addresses: A=10 B=20 (index 0), C=05 and 15 (index 1), D=0A (index 2), E=0F (index 3)
    localparam vec_t VECS [NV] = '{
        '{1,0,8'h10,0,0,8'h00, 1,0,0,0,0,0, 1,0, 2},  // R2 read miss alone
        '{1,0,8'h10,0,0,8'h00, 0,0,0,0,0,1, 1,0, 3},  // R3 read hit
        '{1,1,8'h10,0,0,8'h00, 0,0,0,0,0,1, 3,0, 4},  // R4 excl -> dirty
        '{1,1,8'h10,0,0,8'h00, 0,0,0,0,0,1, 3,0, 4},  // R4 dirty stays
        '{0,0,8'h00,0,1,8'h10, 0,1,0,1,0,0, 0,2, 7},  // R7 snoop read dirty flush
        '{1,1,8'h10,1,0,8'h00, 3,1,0,0,0,1, 2,0, 5},  // R5 shared write, sl high
        '{1,1,8'h10,0,0,8'h00, 3,1,0,0,0,1, 1,0, 5},  // R5 shared write, sl low
        '{0,0,8'h00,0,1,8'h10, 0,0,0,1,0,0, 0,2, 7},  // R7 snoop read excl
        '{0,0,8'h00,0,1,8'h10, 0,0,0,1,0,0, 0,2, 7},  // R7 snoop read shared
        '{0,0,8'h00,0,2,8'h10, 0,0,0,1,1,0, 0,2, 8},  // R8 snoop update shared
        '{1,0,8'h05,1,0,8'h00, 1,0,0,0,0,0, 2,0, 2},  // R2 read miss, sl high
        '{1,1,8'h0A,0,0,8'h00, 2,0,0,0,0,0, 3,0, 6},  // R6 write miss, sl low
        '{1,1,8'h0F,1,0,8'h00, 2,1,0,0,0,0, 2,0, 6},  // R6 write miss, sl high
        '{0,0,8'h00,0,3,8'h0A, 0,1,0,1,1,0, 0,2, 8},  // R8 snoop wrmiss dirty
        '{0,0,8'h00,0,1,8'h20, 0,0,0,0,0,0, 0,0, 9},  // R9 tag mismatch
        '{0,0,8'h00,0,1,8'h0B, 0,0,0,0,0,0, 0,0, 9},  // R9 tag mismatch idx3
        '{1,0,8'h10,0,0,8'h00, 0,0,0,0,0,1, 2,0, 9},  // R9 line unchanged
        '{1,1,8'h10,0,0,8'h00, 3,1,0,0,0,1, 1,0, 5},  // R5
        '{1,1,8'h10,0,0,8'h00, 0,0,0,0,0,1, 3,0, 4},  // R4
        '{1,0,8'h20,0,0,8'h00, 1,0,1,0,0,0, 1,0,10},  // R10 dirty victim
        '{1,0,8'h10,1,0,8'h00, 1,0,0,0,0,0, 2,0,12},  // R12 R10 clean victim
        '{1,1,8'h10,0,0,8'h00, 3,1,0,0,0,1, 1,0, 5},  // R5
        '{1,1,8'h10,0,0,8'h00, 0,0,0,0,0,1, 3,0, 4},  // R4
        '{1,1,8'h10,1,1,8'h10, 3,1,0,1,0,1, 2,2,11},  // R11 snoop flush then update
        '{1,0,8'h05,0,3,8'h05, 0,0,0,1,1,1, 2,2,11},  // R11 read hit with wrmiss snoop
        '{1,1,8'h0A,0,1,8'h0F, 3,1,0,1,0,1, 1,2,11},  // R11 different lines
        '{0,0,8'h00,0,0,8'h00, 0,0,0,0,0,0, 0,0, 3},  // R3 idle
        '{0,0,8'h00,0,2,8'h0A, 0,0,0,1,1,0, 0,2, 8},  // R8 snoop update excl
        '{1,1,8'h20,0,0,8'h00, 2,0,0,0,0,0, 3,0,12},  // R12 displace clean line
        '{1,1,8'h10,1,0,8'h00, 2,1,1,0,0,0, 2,0,10},  // R10 dirty victim on write miss
        '{0,0,8'h00,0,3,8'h0F, 0,0,0,1,1,0, 0,2, 8},  // R8 snoop wrmiss shared
        '{1,1,8'h05,0,0,8'h00, 3,1,0,0,0,1, 1,0, 5},  // R5
        '{1,1,8'h05,0,0,8'h00, 0,0,0,0,0,1, 3,0, 4},  // R4
        '{1,0,8'h15,0,1,8'h05, 1,1,0,1,0,0, 1,2,11}   // R11 snoop cleans victim
    };

    // Purpose: drive one cycle, sample mid-cycle, compare all outputs.
    task automatic run_vec(input vec_t v, input int n);
        logic [10:0] act, exp;
        @(negedge clk);
        cpu_valid = v.cv; cpu_write = v.cw; cpu_addr = v.ca; sl_in = v.sl;
        snoop_kind = v.sk; snoop_addr = v.sa;
        #5;
        act = {bus_cmd, mem_upd, evict_wb, sl_drive, snoop_local_upd, cpu_hit,
               cpu_next_state, snoop_next_state};
        exp = {v.cmd, v.mem, v.ev, v.sld, v.loc, v.hit, v.cn, v.sn};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d step %0d: actual=%b expected=%b", v.req, n, act, exp);
        end
    endtask

    initial begin
        vec_t rv;
        // R1: outputs idle while reset is held
        repeat (3) @(posedge clk);
        rv = '{0,0,8'h00,0,0,8'h00, 0,0,0,0,0,0, 0,0, 1};
        run_vec(rv, -1);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R1: reset in mid-run empties all lines
        @(negedge clk); rst_n = 1'b0;
        rv = '{0,0,8'h00,0,0,8'h00, 0,0,0,0,0,0, 0,0, 1};
        run_vec(rv, 100);
        @(negedge clk); rst_n = 1'b1;
        rv = '{1,0,8'h10,0,0,8'h00, 1,0,0,0,0,0, 1,0, 1}; run_vec(rv, 101);
        rv = '{1,0,8'h15,0,0,8'h00, 1,0,0,0,0,0, 1,0, 1}; run_vec(rv, 102);
        rv = '{1,0,8'h0A,0,0,8'h00, 1,0,0,0,0,0, 1,0, 1}; run_vec(rv, 103);
        rv = '{0,0,8'h00,0,1,8'h0F, 0,0,0,0,0,0, 0,0, 1}; run_vec(rv, 104);
        @(negedge clk);
        cpu_valid = 1'b0; snoop_kind = 2'd0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Purpose: watchdog ends a hung run as a failure.
    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule